// File: doc/BRIEF.md
# Idle-Gap Framed Nibble Transmitter

This block sends one 4-bit value at a time over a single wire. The wire rests high. Each transfer is a short burst: one low start bit, then the four data bits with the least significant bit first, then a direct return to the high resting level. There is no stop bit. Every bit lasts a fixed number of system clocks, set by a parameter.

Before any start bit, the block holds the line high for a minimum number of bit-times. A receiver can therefore wait for a high stretch of that length and then lock onto the next falling edge. The block does not accept a request until that gap has passed.

A client drives the nibble together with a valid strobe. The transfer is taken on a clock edge where both valid and ready are high. At that edge the nibble is copied into a holding register, so the client may change the data bus at once. Reset is asynchronous and active low. Its release is synchronised to the clock, which adds two cycles before the block starts counting.

Top module: `gapframe_tx`

## Requirements
- R1: While reset is asserted, and once it is asserted, `line_out` is 1, `busy` is 0 and `req_ready` is 0.
- R2: `req_ready` rises only after the line has been idle high for GAP_BITS*BIT_CYCLES consecutive cycles. This gap is counted from the cycle after a frame ends, or from the third cycle after reset is released, because the release synchroniser adds two cycles.
- R3: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. From the next cycle, `line_out` is 0 and `busy` is 1 for exactly BIT_CYCLES cycles (the start bit).
- R4: After the start bit, the four data bits appear on `line_out`, bit 0 first and bit 3 last. Each bit lasts BIT_CYCLES cycles.
- R5: In the cycle after the fourth data bit, `line_out` is 1 and `busy` is 0, with no stop bit. A whole frame therefore lasts 5*BIT_CYCLES cycles.
- R6: The nibble is captured on the accepting edge. Later changes on `req_data` during the frame have no effect on the bits sent.
- R7: While `req_ready` is 0, a held `req_valid` starts nothing: the line stays high and `busy` stays 0. The frame starts on the first edge at which ready is 1.
- R8: With `req_valid` low, an idle block keeps `line_out` at 1, `busy` at 0 and `req_ready` at 1 indefinitely.
- R9: If reset is asserted in the middle of a frame, `line_out` returns to 1 and `busy` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client offers a nibble |
| req_data | input | 4 | Nibble to send |
| req_ready | output | 1 | Idle and minimum gap satisfied |
| line_out | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame (start or data bits) in progress |

## Verification
The bench builds the block with BIT_CYCLES=4 and GAP_BITS=5. With a bit length that differs from the default of 6, a design that hard-wires six cycles per bit gives the wrong start-bit length, bit positions and gap count. A short bit time also keeps each frame and gap to a few dozen cycles. The bench can then run many nibble patterns, a request held through the gap, and a reset during the data bits within a small run.

// File: rtl/gft_pkg.sv
package gft_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2
  } gft_state_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/gft_rst_sync.sv
module gft_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/gft_bit_timer.sv
module gft_bit_timer #(
  parameter int unsigned BIT_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CW = gft_pkg::idx_width(BIT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);

  logic [CW-1:0] cyc_q, cyc_n;

  always_comb begin
    tick_o = (cyc_q == LAST);
    if (restart_i || tick_o) cyc_n = '0;
    else                     cyc_n = cyc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_n;
  end

  // R4: the cycle counter never leaves the bit period
  assert_cyc_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q <= LAST);
endmodule

// File: rtl/gft_gap_tracker.sv
module gft_gap_tracker #(
  parameter int unsigned GAP_BITS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic tick_i,
  output logic gap_ok_o
);
  localparam int unsigned GW = gft_pkg::idx_width(GAP_BITS + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(GAP_BITS);

  logic [GW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en   = tick_i && (cnt_q != GAP_MAX);
    gap_ok_o = (cnt_q == GAP_MAX);
    if (clear_i)     cnt_n = '0;
    else if (cnt_en) cnt_n = cnt_q + 1'b1;
    else             cnt_n = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R2: the idle bit count saturates at the gap length
  assert_gap_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= GAP_MAX);
  // R2: the gap only grows by one bit per bit tick
  assert_gap_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/gft_nibble_hold.sv
module gft_nibble_hold #(
  parameter int unsigned DATA_W = 4
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    load_i,
  input  logic [DATA_W-1:0]                       data_i,
  input  logic [gft_pkg::idx_width(DATA_W)-1:0]   sel_i,
  output logic                                    bit_o
);
  logic [DATA_W-1:0] hold_q, hold_n;

  always_comb begin
    hold_n = load_i ? data_i : hold_q;
    bit_o  = hold_q[sel_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_n;
  end

  // R6: the captured nibble only changes on a load
  assert_hold_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(hold_q));
endmodule

// File: rtl/gapframe_tx.sv
module gapframe_tx
  import gft_pkg::*;
#(
  parameter int unsigned BIT_CYCLES = 6,
  parameter int unsigned GAP_BITS   = 5,
  parameter int unsigned DATA_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  output logic              line_out,
  output logic              busy
);
  localparam int unsigned IW = idx_width(DATA_W);
  localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

  logic          rst_i_n;
  gft_state_e    st_q, st_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          line_q, line_n;
  logic          accept, tick, gap_ok, restart, load, gap_clear, cur_bit;

  gft_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_i_n)
  );

  gft_bit_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .restart_i(restart),
    .tick_o   (tick)
  );

  gft_gap_tracker #(.GAP_BITS(GAP_BITS)) u_gap (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clear_i (gap_clear),
    .tick_i  (tick),
    .gap_ok_o(gap_ok)
  );

  gft_nibble_hold #(.DATA_W(DATA_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_i_n),
    .load_i(load),
    .data_i(req_data),
    .sel_i (idx_n),
    .bit_o (cur_bit)
  );

  always_comb begin
    st_n    = st_q;
    idx_n   = idx_q;
    line_n  = line_q;
    restart = 1'b0;
    load    = 1'b0;
    accept  = (st_q == ST_IDLE) && gap_ok && req_valid;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_n    = ST_START;
          idx_n   = '0;
          line_n  = 1'b0;
          restart = 1'b1;
          load    = 1'b1;
        end
      end
      ST_START: begin
        if (tick) begin
          st_n   = ST_DATA;
          line_n = cur_bit;
        end
      end
      ST_DATA: begin
        if (tick) begin
          if (idx_q == LAST_IDX) begin
            st_n    = ST_IDLE;
            line_n  = 1'b1;
            restart = 1'b1;
          end else begin
            idx_n  = idx_q + 1'b1;
            line_n = cur_bit;
          end
        end
      end
      default: begin
        st_n   = ST_IDLE;
        line_n = 1'b1;
      end
    endcase
    gap_clear = (st_q != ST_IDLE) || accept;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      line_q <= 1'b1;
    end else begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      line_q <= line_n;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign req_ready = (st_q == ST_IDLE) && gap_ok;
  assign line_out  = line_q;

  // R3: a frame always opens with the line low
  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(busy) |-> !line_out);
  // R7: a frame only begins after a ready-and-valid edge
  assert_accept_ready_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(busy) |-> $past(req_ready && req_valid));
  // R8: the line rests high whenever no frame is running
  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    !busy |-> line_out);
  // R5: a frame ends straight into idle, with the gap restarted
  assert_end_idle_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(busy) |-> (line_out && !req_ready));
endmodule

// File: tb/gapframe_tx_bench.sv
`timescale 1ns/1ps
module gapframe_tx_bench;
  localparam int BC  = 4;
  localparam int GB  = 5;
  localparam int GAP = GB * BC;
  localparam int NV  = 7;
  // entry = {change_data_during_frame, nibble}
  localparam logic [4:0] VEC [NV] = '{
    5'b0_0000, 5'b0_1111, 5'b1_1010, 5'b0_0101,
    5'b0_0001, 5'b1_1000, 5'b0_0110
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [3:0] req_data;
  logic       req_ready, line_out, busy;
  int         errors = 0;
  int         checks = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  gapframe_tx #(.BIT_CYCLES(BC), .GAP_BITS(GB), .DATA_W(4)) u_gapframe_tx (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
    .req_ready(req_ready), .line_out(line_out), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge where req_ready=1 and req_valid=1 with data d.
  task automatic run_frame(input logic [3:0] d, input bit mut);
    bit bad;
    int cnt;
    @(negedge clk);
    req_valid = 1'b0;
    if (mut) req_data = ~d;
    bad = 0;
    for (int k = 0; k < BC; k++) begin
      if (line_out !== 1'b0 || busy !== 1'b1) bad = 1;
      @(negedge clk);
    end
    chk(!bad, "R3 start bit", bad, 0);
    for (int i = 0; i < 4; i++) begin
      bad = 0;
      for (int k = 0; k < BC; k++) begin
        if (line_out !== d[i] || busy !== 1'b1) bad = 1;
        @(negedge clk);
      end
      chk(!bad, mut ? "R6 captured bit" : "R4 data bit", bad ? int'(~d[i]) : int'(d[i]), int'(d[i]));
    end
    chk(line_out === 1'b1 && busy === 1'b0, "R5 return to idle", {line_out, busy}, 2);
    cnt = 0;
    while (req_ready !== 1'b1 && cnt < 1000) begin
      if (line_out !== 1'b1) cnt = 2000;
      cnt++;
      @(negedge clk);
    end
    chk(cnt == GAP, "R2 gap after frame", cnt, GAP);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    bit bad;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_data = 4'h0;
    repeat (3) @(negedge clk);
    chk(line_out === 1'b1 && busy === 1'b0 && req_ready === 1'b0,
        "R1 reset outputs", {line_out, busy, req_ready}, 4);

    // R7 / R2: request held through the post-reset gap
    req_valid = 1'b1;
    req_data  = 4'b1101;
    rst_n = 1'b1;
    cnt = 0;
    bad = 0;
    @(negedge clk);
    while (req_ready !== 1'b1 && cnt < 1000) begin
      if (busy !== 1'b0 || line_out !== 1'b1) bad = 1;
      cnt++;
      @(negedge clk);
    end
    chk(!bad, "R7 held request waits", bad, 0);
    chk(cnt == GAP + 1, "R2 gap after reset", cnt, GAP + 1);
    run_frame(4'b1101, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      req_data  = VEC[v][3:0];
      req_valid = 1'b1;
      run_frame(VEC[v][3:0], VEC[v][4]);
    end

    // R8: idle without request
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      if (line_out !== 1'b1 || busy !== 1'b0 || req_ready !== 1'b1) bad = 1;
      @(negedge clk);
    end
    chk(!bad, "R8 quiet idle", bad, 0);

    // R9: reset in the middle of data bits
    req_data  = 4'b0000;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2 * BC) @(negedge clk);
    chk(line_out === 1'b0 && busy === 1'b1, "R9 frame running", {line_out, busy}, 1);
    #2 rst_n = 1'b0;
    #1;
    chk(line_out === 1'b1 && busy === 1'b0 && req_ready === 1'b0,
        "R9 async reset mid-frame", {line_out, busy, req_ready}, 4);
    @(negedge clk);
    rst_n = 1'b1;
    cnt = 0;
    @(negedge clk);
    while (req_ready !== 1'b1 && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == GAP + 1, "R2 gap after mid-frame reset", cnt, GAP + 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule